// File: doc/BRIEF.md
# Current-Limit Chopping Timer

This block keeps the current in an H-bridge load within its limit by chopping. While the block runs, it watches a limit comparator. When that comparator reports that the current has reached the limit, the block asks the bridge controller to release the outputs for a fixed switch-off interval. It then turns the bridge back on. For a fixed blanking interval after that, the block ignores the limit comparator, because the switching transient would otherwise retrigger it at once. After blanking, the next limit hit starts a new switch-off interval. The chopping period is therefore the switch-off time plus the blanking time. The default parameters keep a 3:2 ratio between the two intervals.

A second comparator reports a higher short-circuit threshold. A hit on it does not cause chopping. The block goes straight to a latched shutdown, keeps the bridge released, and emits a one-cycle fault pulse. Only dropping the run request clears the latched shutdown. Dropping the run request at any point returns the block to idle. A sticky, active-low diagnostic flag records that a limit event has occurred. It stays low until the diagnostic side clears it.

Top module: `ilim_chopper`

## Requirements
- R1: While reset is asserted, and after it is released with the run request low, the bridge-off request is 1, and the limit-active, fault pulse and flag outputs are 0, 0 and 1 respectively.
- R2: With the block idle, a run request turns the bridge on (bridge-off request 0) one clock after it is first sampled high.
- R3: A limit hit sampled while the bridge is on and not blanking starts a switch-off phase one clock later. The phase lasts exactly OFF_CYCLES cycles, with the bridge-off request at 1 and limit-active at 1.
- R4: A blanking phase of exactly BLANK_CYCLES cycles follows every switch-off phase, with the bridge-off request at 0 and limit-active at 1. The limit input has no effect during switch-off and blanking.
- R5: After blanking, the bridge stays on with limit-active at 0. A limit hit then starts a new switch-off phase as in R3.
- R6: A short-circuit hit sampled while running (on, switch-off or blanking) moves the block to a latched shutdown one clock later. The short-circuit hit takes priority over a limit hit in the same cycle. In shutdown the bridge-off request is 1, limit-active is 0, and neither comparator has any effect until the run request drops.
- R7: The fault output is high for exactly one cycle, the first cycle of the latched shutdown.
- R8: Dropping the run request returns the block to idle one clock later from any state: bridge-off request 1, limit-active 0. This takes priority over both comparators.
- R9: The flag output goes to 0 one clock after a limit hit starts a switch-off phase. It stays 0 until a clear is sampled, which returns it to 1 one clock later. When an event and a clear coincide, the event wins.
- R10: In idle, the limit and short-circuit inputs have no effect, and limit-active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run request; low returns to idle and clears a latched shutdown |
| lim_hit_i | input | 1 | Limit comparator, already temperature-adjusted |
| sc_hit_i | input | 1 | Short-circuit comparator (higher threshold) |
| lim_flag_clr_i | input | 1 | Clears the sticky limit flag |
| bridge_off_o | output | 1 | 1 asks the bridge controller to release both outputs |
| limit_active_o | output | 1 | 1 during switch-off and blanking phases |
| sc_fault_o | output | 1 | One-cycle pulse on entry to the latched shutdown |
| lim_flag_n_o | output | 1 | Sticky limit-event flag, 0 after an event |

## Verification
The assertions assume that the comparator bits and the run request are synchronous to the clock and are sampled once per edge. They also assume that a short-circuit hit counts only while the block is running. The stimulus changes every input only at the falling clock edge. It holds the limit input high through whole switch-off and blanking phases to show that the input is masked there. It also raises both comparators together and drops the run request inside switch-off and inside shutdown, so the priority orderings are exercised.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ON    = 3'd1,
    ST_OFF   = 3'd2,
    ST_BLANK = 3'd3,
    ST_FAULT = 3'd4
  } chop_state_e;
endpackage

// File: rtl/ilim_phase_timer.sv
module ilim_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // load wins; otherwise count down and stop at zero
  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ilim_fsm.sv
module ilim_fsm
  import ilim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic        lim_hit_i,
  input  logic        sc_hit_i,
  input  logic        expired,
  output chop_state_e state_q,
  output logic        load_off,
  output logic        load_blank,
  output logic        lim_event,
  output logic        fault_entry
);
  chop_state_e state_d;

  always_comb begin
    state_d    = state_q;
    load_off   = 1'b0;
    load_blank = 1'b0;
    if (!run_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_ON;
        ST_ON: begin
          if (sc_hit_i) state_d = ST_FAULT;
          else if (lim_hit_i) begin
            state_d  = ST_OFF;
            load_off = 1'b1;
          end
        end
        ST_OFF: begin
          if (sc_hit_i) state_d = ST_FAULT;
          else if (expired) begin
            state_d    = ST_BLANK;
            load_blank = 1'b1;
          end
        end
        ST_BLANK: begin
          if (sc_hit_i)     state_d = ST_FAULT;
          else if (expired) state_d = ST_ON;
        end
        ST_FAULT: state_d = ST_FAULT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign lim_event   = load_off;
  assign fault_entry = (state_d == ST_FAULT) && (state_q != ST_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ilim_diag.sv
module ilim_diag (
  input  logic clk,
  input  logic rst_n,
  input  logic lim_event,
  input  logic flag_clr,
  input  logic fault_entry,
  output logic flag_n,
  output logic fault_pulse
);
  logic flag_n_d, flag_en;

  always_comb begin
    flag_en  = lim_event | flag_clr;
    flag_n_d = ~lim_event;  // event wins over a coincident clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_n <= 1'b1;
    else if (flag_en) flag_n <= flag_n_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_pulse <= 1'b0;
    else        fault_pulse <= fault_entry;
  end
endmodule

// File: rtl/ilim_chopper.sv
module ilim_chopper
  import ilim_pkg::*;
#(
  parameter int OFF_CYCLES   = 12,
  parameter int BLANK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic lim_hit_i,
  input  logic sc_hit_i,
  input  logic lim_flag_clr_i,
  output logic bridge_off_o,
  output logic limit_active_o,
  output logic sc_fault_o,
  output logic lim_flag_n_o
);
  localparam int MAXC = (OFF_CYCLES > BLANK_CYCLES) ? OFF_CYCLES : BLANK_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] OFF_LD   = CW'(OFF_CYCLES - 1);
  localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYCLES - 1);

  chop_state_e   state_q;
  logic          load_off, load_blank, expired, lim_event, fault_entry;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;

  ilim_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .lim_hit_i   (lim_hit_i),
    .sc_hit_i    (sc_hit_i),
    .expired     (expired),
    .state_q     (state_q),
    .load_off    (load_off),
    .load_blank  (load_blank),
    .lim_event   (lim_event),
    .fault_entry (fault_entry)
  );

  assign tmr_load = load_off | load_blank;
  assign tmr_val  = load_off ? OFF_LD : BLANK_LD;

  ilim_phase_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  ilim_diag u_diag (
    .clk         (clk),
    .rst_n       (rst_n),
    .lim_event   (lim_event),
    .flag_clr    (lim_flag_clr_i),
    .fault_entry (fault_entry),
    .flag_n      (lim_flag_n_o),
    .fault_pulse (sc_fault_o)
  );

  assign bridge_off_o   = (state_q == ST_IDLE) || (state_q == ST_OFF) || (state_q == ST_FAULT);
  assign limit_active_o = (state_q == ST_OFF) || (state_q == ST_BLANK);
endmodule

// File: rtl/ilim_chopper_chk.sv
module ilim_chopper_chk (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic lim_hit_i,
  input logic sc_hit_i,
  input logic bridge_off_o,
  input logic limit_active_o,
  input logic sc_fault_o,
  input logic lim_flag_n_o
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fault_o |=> !sc_fault_o);

  a_r6_fault_releases_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fault_o |-> (bridge_off_o && !limit_active_o));

  a_r6_short_shuts_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && sc_hit_i && !bridge_off_o) |=> (bridge_off_o && !limit_active_o));

  a_r8_run_low_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (bridge_off_o && !limit_active_o && !sc_fault_o));

  a_r3_chop_starts_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(limit_active_o) |-> bridge_off_o);

  a_r9_flag_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lim_flag_n_o) |-> ($past(lim_hit_i) && $past(run_i)));
endmodule

bind ilim_chopper ilim_chopper_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .run_i          (run_i),
  .lim_hit_i      (lim_hit_i),
  .sc_hit_i       (sc_hit_i),
  .bridge_off_o   (bridge_off_o),
  .limit_active_o (limit_active_o),
  .sc_fault_o     (sc_fault_o),
  .lim_flag_n_o   (lim_flag_n_o)
);

// File: tb/ilim_chopper_test.sv
module ilim_chopper_test;
  localparam int OFFC = 12;
  localparam int BLKC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic run, lim, sc, clr;
  logic bridge_off, lim_act, sc_fault, flag_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ilim_chopper #(.OFF_CYCLES(OFFC), .BLANK_CYCLES(BLKC)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_i          (run),
    .lim_hit_i      (lim),
    .sc_hit_i       (sc),
    .lim_flag_clr_i (clr),
    .bridge_off_o   (bridge_off),
    .limit_active_o (lim_act),
    .sc_fault_o     (sc_fault),
    .lim_flag_n_o   (flag_n)
  );

  // behavioural reference: 0 idle, 1 on, 2 off, 3 blank, 4 fault
  int m_st   = 0;
  int m_rem  = 0;
  bit m_flag = 1'b1;
  bit m_puls = 1'b0;

  task automatic model_step();
    int old_st = m_st;
    if (!run) m_st = 0;
    else if (m_st == 0) m_st = 1;
    else if (m_st == 1) begin
      if (sc) m_st = 4;
      else if (lim) begin m_st = 2; m_rem = OFFC; end
    end else if (m_st == 2) begin
      if (sc) m_st = 4;
      else begin
        m_rem--;
        if (m_rem == 0) begin m_st = 3; m_rem = BLKC; end
      end
    end else if (m_st == 3) begin
      if (sc) m_st = 4;
      else begin
        m_rem--;
        if (m_rem == 0) m_st = 1;
      end
    end
    m_puls = (m_st == 4) && (old_st != 4);
    if (old_st == 1 && m_st == 2) m_flag = 1'b0;
    else if (clr) m_flag = 1'b1;
  endtask

  task automatic compare(string tag);
    bit e_off = (m_st == 0) || (m_st == 2) || (m_st == 4);
    bit e_act = (m_st == 2) || (m_st == 3);
    n_tests++;
    if (bridge_off !== e_off || lim_act !== e_act || sc_fault !== m_puls || flag_n !== m_flag) begin
      n_fail++;
      $display("FAIL %s: got off=%b act=%b flt=%b flag_n=%b expected off=%b act=%b flt=%b flag_n=%b",
               tag, bridge_off, lim_act, sc_fault, flag_n, e_off, e_act, m_puls, m_flag);
    end
  endtask

  task automatic cyc(bit r, bit l, bit s, bit c, string tag);
    run = r; lim = l; sc = s; clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; lim = 1'b0; sc = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, "R1 after release");
    // R10: comparators ignored in idle
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, "R10 idle");
    // R2: start running
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R2 run");
    // R3 R4 R5: limit held high through off, blank and retrigger
    for (int i = 0; i < 45; i++) cyc(1, 1, 0, 0, "R3 R4 R5 chop");
    // R9: clear held while events keep occurring, then clear alone
    for (int i = 0; i < 25; i++) cyc(1, 1, 0, 1, "R9 clear vs event");
    for (int i = 0; i < 25; i++) cyc(1, 0, 0, 1, "R9 clear");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R5 on");
    // R6 R7: short during blanking
    cyc(1, 1, 0, 0, "R3 hit");
    for (int i = 0; i < OFFC + 2; i++) cyc(1, 0, 0, 0, "R4 into blank");
    cyc(1, 0, 1, 0, "R6 short in blank");
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, "R6 R7 latched");
    // R8: run low clears shutdown
    for (int i = 0; i < 2; i++) cyc(0, 0, 1, 0, "R8 leave fault");
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, "R2 restart");
    // R6: short and limit together while on
    cyc(1, 1, 1, 0, "R6 priority");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R7 pulse");
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, "R8 idle");
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, "R2 restart");
    // R6: short during switch-off
    cyc(1, 1, 0, 0, "R3 hit");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, "R3 off");
    cyc(1, 0, 1, 0, "R6 short in off");
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, "R8 idle");
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 0, "R2 restart");
    // R8: run drops mid switch-off with limit still high
    cyc(1, 1, 0, 0, "R3 hit");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, "R3 off");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, "R8 drop in off");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule